// File: doc/BRIEF.md
# Tick-Synchronized Register Write Port

This block is the host-facing register port of a low-speed real-time clock. Its control and data registers (time, alarm, stopwatch count, interrupt enable and divider enable) sit behind a slow timing domain. A bus write to one of them is not applied on the bus cycle. The port captures the write and holds it, and it commits the value on the next slow synchronization tick. While a captured write is waiting, any further write to a synchronized register is dropped without an error, so the first value wins. The tick source depends on the committed divider-enable bit. When the bit is 1, the port uses the once-per-second tick. When it is 0, the port uses the raw crystal edge, which is far more frequent.

The status register is outside this scheme. It shows the event flags fed in from the clock's event logic, a pending flag and a completion flag. Writing ones to it clears the matching flags in the same cycle. The interrupt output combines the flags with the committed enable mask. A flag still sets when its enable bit is off.

Top module: `rtc_sync_wport`

## Requirements
- R1: After reset every register reads 0, the status reads 0, the divider enable reads 0 and irq is low.
- R2: A read of a synchronized register (addresses 0 to 4) returns the committed value, never a held value that has not yet been applied.
- R3: A held write is applied on the first sync tick after the cycle in which it was accepted. The sync tick is tick1Hz when the committed divider enable (address 4, bit 0) is 1, and rawEdge when it is 0. The other pulse has no effect.
- R4: A write to a synchronized register while another write is pending is discarded, and the earlier value is the one applied.
- R5: Status bit 14 reads 1 from the cycle after a write is accepted until the cycle after it is applied.
- R6: Status bit 15 sets in the cycle after a write is applied, and writing 1 to bit 15 clears it.
- R7: A write to status (address 5) takes effect at once. Each 1 clears the matching flag, and the write never sets bit 14. Event flag i (status bit i, i below NEVT) sets from evtIn[i], and a set wins over a clear in the same cycle.
- R8: irq is high exactly when a status flag (bit 15 or an event bit) is 1 and its bit in the interrupt enable register (address 3) is 1. Flags set whatever the state of their enable bits.
- R9: In the cycle a held write is applied, applyStb is 1 and applyAddr and applyData carry that write's address and data. applyStb is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe |
| busAddr | input | 3 | Register select: 0 time, 1 alarm, 2 stopwatch, 3 enable, 4 divider enable, 5 status |
| busWdata | input | DW | Write data |
| busRdata | output | DW | Read data for busAddr, combinational |
| tick1Hz | input | 1 | Divided tick, one-cycle pulse, already synchronized |
| rawEdge | input | 1 | Raw crystal edge, one-cycle pulse, already synchronized |
| evtIn | input | NEVT | Event flag set pulses |
| irq | output | 1 | Interrupt request |
| applyStb | output | 1 | Held write committed this cycle |
| applyAddr | output | 3 | Address of the committed write |
| applyData | output | DW | Data of the committed write |

## Verification
The bench uses the default parameters: a 32-bit data path and seven event flags. With these values it writes full-width time and alarm words and uses an event index inside the flag range. The same run covers both tick sources. It starts with the divider disabled after reset, then enables it through a held write, so the ignored-pulse case is exercised under each setting.

// File: rtl/rtc_sync_wport_pkg.sv
package rtc_sync_wport_pkg;
  localparam int AW  = 3;
  localparam int STW = 16;
  localparam int PEND_BIT = 14;
  localparam int DONE_BIT = 15;

  localparam logic [AW-1:0] SEL_TIME   = 3'd0;
  localparam logic [AW-1:0] SEL_ALARM  = 3'd1;
  localparam logic [AW-1:0] SEL_SWCNT  = 3'd2;
  localparam logic [AW-1:0] SEL_IEN    = 3'd3;
  localparam logic [AW-1:0] SEL_PREN   = 3'd4;
  localparam logic [AW-1:0] SEL_STATUS = 3'd5;

  typedef struct packed {
    logic accept;   // capture bus write into holding register
    logic apply;    // commit holding register this cycle
    logic stsClr;   // write-one-to-clear on status
    logic pending;  // a held write waits for a tick
  } strobes_t;
endpackage

// File: rtl/rtc_sync_wport_ctrl.sv
module rtc_sync_wport_ctrl
  import rtc_sync_wport_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  input  logic          tick1Hz,
  input  logic          rawEdge,
  input  logic          prenQ,
  output strobes_t      strb
);
  logic pendQ;
  logic syncTick;
  logic isSync;

  always_comb begin
    syncTick    = prenQ ? tick1Hz : rawEdge;
    isSync      = (busAddr <= SEL_PREN);
    strb.accept = busWe && isSync && !pendQ;
    strb.apply  = pendQ && syncTick;
    strb.stsClr = busWe && (busAddr == SEL_STATUS);
    strb.pending = pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pendQ <= 1'b0;
    else if (strb.apply)   pendQ <= 1'b0;
    else if (strb.accept)  pendQ <= 1'b1;
  end
endmodule

// File: rtl/rtc_sync_wport_dp.sv
module rtc_sync_wport_dp
  import rtc_sync_wport_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NEVT = 7
)(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [NEVT-1:0] evtIn,
  output logic [DW-1:0] busRdata,
  output logic          irq,
  output logic          prenQ,
  output logic [AW-1:0] holdAddr,
  output logic [DW-1:0] holdData
);
  localparam logic [STW-1:0] IRQ_MASK = ~(STW'(1) << PEND_BIT);

  logic [DW-1:0]   timeQ, alarmQ, swQ;
  logic [STW-1:0]  ienQ;
  logic [NEVT-1:0] evtQ;
  logic            doneQ;
  logic [STW-1:0]  clrMask;
  logic [STW-1:0]  stsView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
    end else if (strb.accept) begin
      holdAddr <= busAddr;
      holdData <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ  <= '0;
      alarmQ <= '0;
      swQ    <= '0;
      ienQ   <= '0;
      prenQ  <= 1'b0;
    end else if (strb.apply) begin
      case (holdAddr)
        SEL_TIME:  timeQ  <= holdData;
        SEL_ALARM: alarmQ <= holdData;
        SEL_SWCNT: swQ    <= holdData;
        SEL_IEN:   ienQ   <= holdData[STW-1:0];
        SEL_PREN:  prenQ  <= holdData[0];
        default: ;
      endcase
    end
  end

  always_comb clrMask = strb.stsClr ? busWdata[STW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      evtQ  <= (evtQ & ~clrMask[NEVT-1:0]) | evtIn;
      doneQ <= strb.apply | (doneQ & ~clrMask[DONE_BIT]);
    end
  end

  always_comb begin
    stsView = '0;
    stsView[NEVT-1:0] = evtQ;
    stsView[PEND_BIT] = strb.pending;
    stsView[DONE_BIT] = doneQ;
    irq = |(stsView & ienQ & IRQ_MASK);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      SEL_TIME:   busRdata = timeQ;
      SEL_ALARM:  busRdata = alarmQ;
      SEL_SWCNT:  busRdata = swQ;
      SEL_IEN:    busRdata = DW'(ienQ);
      SEL_PREN:   busRdata = DW'(prenQ);
      SEL_STATUS: busRdata = DW'(stsView);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sync_wport.sv
module rtc_sync_wport
  import rtc_sync_wport_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NEVT = 7
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWe,
  input  logic [2:0]      busAddr,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  input  logic            tick1Hz,
  input  logic            rawEdge,
  input  logic [NEVT-1:0] evtIn,
  output logic            irq,
  output logic            applyStb,
  output logic [2:0]      applyAddr,
  output logic [DW-1:0]   applyData
);
  strobes_t strb;
  logic     prenQ;
  logic     pending;

  rtc_sync_wport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .tick1Hz(tick1Hz), .rawEdge(rawEdge), .prenQ(prenQ), .strb(strb)
  );

  rtc_sync_wport_dp #(.DW(DW), .NEVT(NEVT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .evtIn(evtIn), .busRdata(busRdata), .irq(irq),
    .prenQ(prenQ), .holdAddr(applyAddr), .holdData(applyData)
  );

  assign applyStb = strb.apply;
  assign pending  = strb.pending;
endmodule

// File: rtl/rtc_sync_wport_chk.sv
module rtc_sync_wport_chk #(
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rstN,
  input logic          busWe,
  input logic [2:0]    busAddr,
  input logic          tick1Hz,
  input logic          rawEdge,
  input logic          applyStb,
  input logic [DW-1:0] applyData,
  input logic          pending,
  input logic          prenQ
);
  assert_accept_sets_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr <= 3'd4 && !pending) |=> pending);

  assert_drop_keeps_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && busWe && !applyStb) |=> $stable(applyData));

  assert_slow_tick_applies_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pending && prenQ && tick1Hz) |=> !pending);

  assert_raw_edge_applies_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !prenQ && rawEdge) |=> !pending);

  assert_status_write_no_pend_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd5 && !pending) |=> !pending);

  assert_apply_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    applyStb |=> !applyStb);
endmodule

bind rtc_sync_wport rtc_sync_wport_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .tick1Hz(tick1Hz), .rawEdge(rawEdge), .applyStb(applyStb),
  .applyData(applyData), .pending(pending), .prenQ(prenQ)
);

// File: tb/rtc_sync_wport_bench.sv
module rtc_sync_wport_bench;
  localparam int DW = 32;
  localparam int NEVT = 7;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_RE = 2'd3;
  localparam int NV = 22;
  // {req[3:0], op[1:0], addr[2:0], data[31:0], exp[31:0]}
  localparam logic [72:0] VEC [NV] = '{
    {4'd1, OP_RD, 3'd5, 32'h0,    32'h0},      // R1 status
    {4'd1, OP_RD, 3'd4, 32'h0,    32'h0},      // R1 divider enable
    {4'd2, OP_WR, 3'd0, 32'h1234, 32'h0},
    {4'd5, OP_RD, 3'd5, 32'h0,    32'h4000},   // R5 pending
    {4'd2, OP_RD, 3'd0, 32'h0,    32'h0},      // R2 committed only
    {4'd4, OP_WR, 3'd0, 32'h9999, 32'h0},      // R4 dropped
    {4'd3, OP_TK, 3'd0, 32'h0,    32'h0},      // R3 ignored while divider off
    {4'd3, OP_RD, 3'd5, 32'h0,    32'h4000},
    {4'd3, OP_RE, 3'd0, 32'h0,    32'h0},
    {4'd4, OP_RD, 3'd0, 32'h0,    32'h1234},   // R4 first value applied
    {4'd6, OP_RD, 3'd5, 32'h0,    32'h8000},   // R6 done set
    {4'd6, OP_WR, 3'd5, 32'h8000, 32'h0},
    {4'd6, OP_RD, 3'd5, 32'h0,    32'h0},      // R6 cleared
    {4'd3, OP_WR, 3'd4, 32'h1,    32'h0},
    {4'd3, OP_RE, 3'd0, 32'h0,    32'h0},
    {4'd3, OP_RD, 3'd4, 32'h0,    32'h1},
    {4'd3, OP_WR, 3'd1, 32'hABCD, 32'h0},
    {4'd3, OP_RE, 3'd0, 32'h0,    32'h0},      // R3 ignored while divider on
    {4'd5, OP_RD, 3'd5, 32'h0,    32'hC000},
    {4'd3, OP_TK, 3'd0, 32'h0,    32'h0},
    {4'd3, OP_RD, 3'd1, 32'h0,    32'hABCD},
    {4'd6, OP_RD, 3'd5, 32'h0,    32'h8000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic tick1Hz = 1'b0, rawEdge = 1'b0;
  logic [NEVT-1:0] evtIn = '0;
  logic irq, applyStb;
  logic [2:0] applyAddr;
  logic [DW-1:0] applyData;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rtc_sync_wport #(.DW(DW), .NEVT(NEVT)) u_rtc_sync_wport (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tick1Hz(tick1Hz),
    .rawEdge(rawEdge), .evtIn(evtIn), .irq(irq), .applyStb(applyStb),
    .applyAddr(applyAddr), .applyData(applyData)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic pulseTick();
    tick1Hz = 1'b1; @(negedge clk); tick1Hz = 1'b0;
  endtask

  task automatic pulseRaw();
    rawEdge = 1'b1; @(negedge clk); rawEdge = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", DW'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[72:69], i);
      case (v[68:67])
        OP_WR: wr(v[66:64], v[63:32]);
        OP_RD: rd(tag, v[66:64], v[31:0]);
        OP_TK: pulseTick();
        default: pulseRaw();
      endcase
    end

    // R8: event sets with enable off, irq stays low
    wr(3'd5, 32'h8000);
    evtIn = 7'b0000100; @(negedge clk); evtIn = '0;
    rd("R8 flag without enable", 3'd5, 32'h0004);
    check("R8 irq masked", DW'(irq), 0);
    wr(3'd3, 32'h0004);
    rd("R8 pending enable", 3'd5, 32'h4004);
    check("R8 irq before apply", DW'(irq), 0);
    pulseTick();
    check("R8 irq enabled", DW'(irq), 1);
    rd("R8 enable reg", 3'd3, 32'h4);

    // R7: immediate clear, no pending
    wr(3'd5, 32'h0004);
    rd("R7 cleared no pending", 3'd5, 32'h8000);
    check("R7 irq low", DW'(irq), 0);
    busWe = 1'b1; busAddr = 3'd5; busWdata = 32'h0001; evtIn = 7'b0000001;
    @(negedge clk);
    busWe = 1'b0; evtIn = '0;
    rd("R7 set wins", 3'd5, 32'h8001);
    wr(3'd5, 32'h8001);
    rd("R7 all cleared", 3'd5, 32'h0);

    // R9: apply strobe
    wr(3'd2, 32'h55);
    check("R9 no strobe before tick", DW'(applyStb), 0);
    tick1Hz = 1'b1;
    #1;
    check("R9 strobe", DW'(applyStb), 1);
    check("R9 addr", DW'(applyAddr), 2);
    check("R9 data", applyData, 32'h55);
    @(negedge clk); tick1Hz = 1'b0;
    check("R9 pulse ends", DW'(applyStb), 0);
    rd("R2 swcnt committed", 3'd2, 32'h55);

    // R8: completion interrupt
    wr(3'd3, 32'h8000);
    pulseTick();
    check("R8 done irq", DW'(irq), 1);
    wr(3'd5, 32'h8000);
    check("R6 R8 clear done irq", DW'(irq), 0);

    // R1: reset with a write pending
    wr(3'd0, 32'h77);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    rd("R1 status after reset", 3'd5, 32'h0);
    rd("R1 time after reset", 3'd0, 32'h0);
    rd("R1 pren after reset", 3'd4, 32'h0);
    check("R1 irq after reset", DW'(irq), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule